// File: doc/BRIEF.md
# Oscillator Drift Tamper Monitor

This block watches a bank of slow sensor oscillators. Each one is an external ring oscillator whose frequency shifts when the capacitive sensor wired into it is damaged or touched. Every oscillator input is synchronized to the system clock, and the block counts its rising edges over a measurement window that a shared timer defines. When a window closes, a comparator shared by each pair of channels checks both counts in turn. It compares each count, corrected by that channel's trim offset, against a common target. A channel that misses the target by more than the allowed tolerance sets its bit in a sticky fault map and raises the alarm toward the processor.

Channel frequencies spread during manufacture, so each channel carries a small trim register. In test mode the alarm is held low and no faults are recorded. Each evaluation then moves the trim by one step toward the target, and a done flag reports when every channel has hit the target exactly. Software leaves test mode once calibration is complete. From then on, any drift away from the calibrated count shows up as a tamper fault.

Top module: `osc_tamper_monitor`

## Requirements
- R1: Each oscillator input passes through two synchronizing flops. A rising edge is counted once, two clock edges after it is captured.
- R2: A window lasts `window_len_i` clock cycles, and values below 2 are treated as 2. Every channel counter restarts at each window boundary. The finished count is held for comparison.
- R3: A channel counter saturates at 255 and does not wrap.
- R4: The corrected value is count + trim − 8. A channel fails when its corrected value differs from `target_i` by more than `tol_i`. Channel 2p is judged in the cycle after a window closes, and channel 2p+1 in the cycle after that. A failure sets `fault_o[channel]`, which is visible one cycle after the judgement.
- R5: `alarm_o` is high whenever any fault bit is set outside test mode. Fault bits stay set until `clear_i` is asserted. `clear_i` clears every fault bit and takes priority over a new failure in the same cycle.
- R6: While `test_mode_i` is high, `alarm_o` is low and no new fault bit is recorded.
- R7: In test mode, each judgement steps the judged channel's trim up by one if the corrected value is below target, or down by one if it is above target. The trim is limited to 0..15. Outside test mode the trims do not change. Channel c's trim appears at `trim_o[4c+3:4c]`.
- R8: In test mode, a channel is marked done when its corrected value equals the target. `cal_done_o` is high when every channel is done. All done marks clear one cycle after test mode is left.
- R9: After reset, `alarm_o`, `fault_o` and `cal_done_o` are 0 and every trim is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | 2*NUM_PAIRS | Raw sensor oscillator inputs, one per channel |
| test_mode_i | input | 1 | Calibration mode enable |
| clear_i | input | 1 | Clears the fault map and alarm |
| window_len_i | input | WIN_W | Window length in clock cycles |
| target_i | input | 8 | Expected corrected count |
| tol_i | input | 8 | Allowed deviation from the target |
| alarm_o | output | 1 | Sticky tamper alarm |
| fault_o | output | 2*NUM_PAIRS | Per-channel sticky fault map |
| cal_done_o | output | 1 | All channels matched the target in test mode |
| trim_o | output | 8*NUM_PAIRS | Per-channel 4-bit trim values |

## Verification
On every cycle, the assertions check that faults are sticky and yield to a clear, and that test mode silences the alarm and blocks new faults. They also check that trims freeze outside test mode, that the done flag drops once test mode ends, and that the alarm follows the fault map. Only the bench scenarios can show the counting itself: synchronizer latency, window restarts, saturation at 255, the staggered two-cycle judgement of a channel pair, the tolerance band, and calibration converging to the expected trim values. The bench covers these by comparing against a behavioural model on every clock.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

    parameter int CNT_W    = 8;
    parameter int TRIM_W   = 4;
    localparam int CNT_MAX  = (1 << CNT_W) - 1;
    localparam int TRIM_MAX = (1 << TRIM_W) - 1;
    localparam int TRIM_MID = 1 << (TRIM_W - 1);

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } trim_step_e;

    typedef struct packed {
        logic       fail;
        trim_step_e step;
    } judge_t;

    // corrected count minus target, compared with a symmetric tolerance
    function automatic judge_t judge(input logic [CNT_W-1:0] cnt,
                                     input logic [TRIM_W-1:0] trim,
                                     input logic [CNT_W-1:0] target,
                                     input logic [CNT_W-1:0] tol);
        judge_t r;
        int d;
        d = int'(cnt) + int'(trim) - TRIM_MID - int'(target);
        r.fail = (d > int'(tol)) || (d < -int'(tol));
        if (d < 0)      r.step = STEP_UP;
        else if (d > 0) r.step = STEP_DOWN;
        else            r.step = STEP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic osc_i,
    output logic rise_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= osc_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;
endmodule

// File: rtl/osc_win_counter.sv
module osc_win_counter
    import osc_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             win_end_i,
    output logic [CNT_W-1:0] snap_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            snap_o <= '0;
        end else if (win_end_i) begin
            snap_o <= cnt_q;
            cnt_q  <= CNT_W'(rise_i);
        end else if (rise_i && cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/osc_win_timer.sv
module osc_win_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] len_i,
    output logic             win_end_o
);
    logic [WIN_W-1:0] tcnt_q, last;

    assign last      = (len_i < WIN_W'(2)) ? WIN_W'(1) : len_i - 1'b1;
    assign win_end_o = (tcnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst)            tcnt_q <= '0;
        else if (win_end_o) tcnt_q <= '0;
        else                tcnt_q <= tcnt_q + 1'b1;
    end
endmodule

// File: rtl/osc_pair_cmp.sv
module osc_pair_cmp
    import osc_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ph_a_i,
    input  logic              ph_b_i,
    input  logic [CNT_W-1:0]  snap_a_i,
    input  logic [CNT_W-1:0]  snap_b_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic [CNT_W-1:0]  tol_i,
    input  logic              test_mode_i,
    input  logic              clear_i,
    output logic [1:0]        fault_o,
    output logic [1:0]        done_o,
    output logic [2*TRIM_W-1:0] trim_o
);
    logic [TRIM_W-1:0] trim_q [2];
    logic              sel, active;
    judge_t            res;

    assign sel    = ph_b_i;
    assign active = ph_a_i | ph_b_i;

    always_comb res = judge(sel ? snap_b_i : snap_a_i, trim_q[sel], target_i, tol_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q[0] <= TRIM_W'(TRIM_MID);
            trim_q[1] <= TRIM_W'(TRIM_MID);
            fault_o   <= '0;
            done_o    <= '0;
        end else begin
            if (clear_i)
                fault_o <= '0;
            else if (active && !test_mode_i && res.fail)
                fault_o[sel] <= 1'b1;

            if (!test_mode_i)
                done_o <= '0;
            else if (active && res.step == STEP_HOLD)
                done_o[sel] <= 1'b1;

            if (active && test_mode_i) begin
                case (res.step)
                    STEP_UP:   if (trim_q[sel] != TRIM_W'(TRIM_MAX)) trim_q[sel] <= trim_q[sel] + 1'b1;
                    STEP_DOWN: if (trim_q[sel] != '0)                trim_q[sel] <= trim_q[sel] - 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    assign trim_o = {trim_q[1], trim_q[0]};
endmodule

// File: rtl/osc_tamper_monitor.sv
module osc_tamper_monitor
    import osc_mon_pkg::*;
#(
    parameter int NUM_PAIRS = 12,
    parameter int WIN_W     = 16,
    localparam int NCH      = 2 * NUM_PAIRS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        osc_i,
    input  logic                  test_mode_i,
    input  logic                  clear_i,
    input  logic [WIN_W-1:0]      window_len_i,
    input  logic [CNT_W-1:0]      target_i,
    input  logic [CNT_W-1:0]      tol_i,
    output logic                  alarm_o,
    output logic [NCH-1:0]        fault_o,
    output logic                  cal_done_o,
    output logic [NCH*TRIM_W-1:0] trim_o
);
    logic             win_end, ph_a, ph_b;
    logic [NCH-1:0]   rise, done;
    logic [CNT_W-1:0] snap [NCH];

    osc_win_timer #(.WIN_W(WIN_W)) u_timer (
        .clk(clk), .rst(rst), .len_i(window_len_i), .win_end_o(win_end)
    );

    // two judgement phases following each window end
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_a <= 1'b0;
            ph_b <= 1'b0;
        end else begin
            ph_a <= win_end;
            ph_b <= ph_a;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        osc_edge_sync u_sync (
            .clk(clk), .rst(rst), .osc_i(osc_i[c]), .rise_o(rise[c])
        );
        osc_win_counter u_cnt (
            .clk(clk), .rst(rst), .rise_i(rise[c]), .win_end_i(win_end), .snap_o(snap[c])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        osc_pair_cmp u_cmp (
            .clk(clk), .rst(rst),
            .ph_a_i(ph_a), .ph_b_i(ph_b),
            .snap_a_i(snap[2*p]), .snap_b_i(snap[2*p+1]),
            .target_i(target_i), .tol_i(tol_i),
            .test_mode_i(test_mode_i), .clear_i(clear_i),
            .fault_o(fault_o[2*p +: 2]),
            .done_o(done[2*p +: 2]),
            .trim_o(trim_o[2*p*TRIM_W +: 2*TRIM_W])
        );
    end

    assign alarm_o    = (|fault_o) & ~test_mode_i;
    assign cal_done_o = &done;
endmodule

// File: rtl/osc_tamper_monitor_chk.sv
module osc_tamper_monitor_chk
    import osc_mon_pkg::*;
#(
    parameter int NUM_PAIRS = 12,
    parameter int WIN_W     = 16,
    localparam int NCH      = 2 * NUM_PAIRS
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  test_mode_i,
    input logic                  clear_i,
    input logic                  alarm_o,
    input logic [NCH-1:0]        fault_o,
    input logic                  cal_done_o,
    input logic [NCH*TRIM_W-1:0] trim_o
);
    // R6
    alarm_quiet_in_test_chk: assert property (@(posedge clk) disable iff (rst)
        test_mode_i |-> !alarm_o);

    // R6
    no_new_fault_in_test_chk: assert property (@(posedge clk) disable iff (rst)
        test_mode_i |=> ((fault_o & ~$past(fault_o)) == '0));

    // R5
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (fault_o == '0));

    // R5
    alarm_follows_map_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_mode_i && fault_o != '0) |-> alarm_o);

    // R7
    trim_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !test_mode_i |=> $stable(trim_o));

    // R8
    done_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !test_mode_i |=> !cal_done_o);
endmodule

bind osc_tamper_monitor osc_tamper_monitor_chk #(.NUM_PAIRS(NUM_PAIRS), .WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst(rst), .test_mode_i(test_mode_i), .clear_i(clear_i),
    .alarm_o(alarm_o), .fault_o(fault_o), .cal_done_o(cal_done_o), .trim_o(trim_o)
);

// File: tb/osc_tamper_monitor_test.sv
module osc_tamper_monitor_test;
    localparam int NP  = 2;
    localparam int NC  = 2 * NP;
    localparam int WW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] osc = '0;
    logic          tm = 1'b0;
    logic          clr = 1'b0;
    logic [WW-1:0] win_len = 16'd64;
    logic [7:0]    target = 8'd10;
    logic [7:0]    tol = 8'd0;
    logic          alarm;
    logic [NC-1:0] fault;
    logic          cal_done;
    logic [NC*4-1:0] trim;

    int errors = 0;
    int checks = 0;
    bit model_on = 0;

    int half [NC];
    int oc   [NC];

    always #10 clk = ~clk;

    osc_tamper_monitor #(.NUM_PAIRS(NP), .WIN_W(WW)) uut (
        .clk(clk), .rst(rst), .osc_i(osc), .test_mode_i(tm), .clear_i(clr),
        .window_len_i(win_len), .target_i(target), .tol_i(tol),
        .alarm_o(alarm), .fault_o(fault), .cal_done_o(cal_done), .trim_o(trim)
    );

    // oscillator stimulus: square waves with a half period in clocks
    initial for (int c = 0; c < NC; c++) begin half[c] = 0; oc[c] = 0; end
    always @(negedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (half[c] > 0) begin
                if (oc[c] + 1 >= half[c]) begin
                    oc[c] = 0;
                    osc[c] = ~osc[c];
                end else begin
                    oc[c] = oc[c] + 1;
                end
            end
        end
    end

    // behavioural reference
    int m_s1[NC], m_s2[NC], m_s3[NC], m_cnt[NC], m_snap[NC], m_trim[NC];
    bit m_flt[NC], m_dn[NC];
    int m_tc;
    bit m_pa, m_pb;
    int m_last, m_ch, m_d;
    bit m_we, m_e;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NC; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0; m_cnt[c] = 0; m_snap[c] = 0;
                m_trim[c] = 8; m_flt[c] = 0; m_dn[c] = 0;
            end
            m_tc = 0; m_pa = 0; m_pb = 0;
        end else begin
            m_last = (win_len < 2) ? 1 : int'(win_len) - 1;
            m_we = (m_tc >= m_last);
            for (int p = 0; p < NP; p++) begin
                if (m_pa || m_pb) begin
                    m_ch = m_pb ? 2*p+1 : 2*p;
                    m_d = m_snap[m_ch] + m_trim[m_ch] - 8 - int'(target);
                    if (!tm && (m_d > int'(tol) || m_d < -int'(tol))) m_flt[m_ch] = 1;
                    if (tm) begin
                        if (m_d == 0) m_dn[m_ch] = 1;
                        if (m_d < 0 && m_trim[m_ch] < 15) m_trim[m_ch] = m_trim[m_ch] + 1;
                        if (m_d > 0 && m_trim[m_ch] > 0)  m_trim[m_ch] = m_trim[m_ch] - 1;
                    end
                end
            end
            if (clr) for (int c = 0; c < NC; c++) m_flt[c] = 0;
            if (!tm) for (int c = 0; c < NC; c++) m_dn[c] = 0;
            for (int c = 0; c < NC; c++) begin
                m_e = (m_s2[c] == 1) && (m_s3[c] == 0);
                if (m_we) begin
                    m_snap[c] = m_cnt[c];
                    m_cnt[c] = m_e ? 1 : 0;
                end else if (m_e && m_cnt[c] < 255) begin
                    m_cnt[c] = m_cnt[c] + 1;
                end
                m_s3[c] = m_s2[c];
                m_s2[c] = m_s1[c];
                m_s1[c] = int'(osc[c]);
            end
            m_tc = m_we ? 0 : m_tc + 1;
            m_pb = m_pa;
            m_pa = m_we;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on && !rst) begin
            logic [NC-1:0] mf;
            bit any, all;
            any = 0; all = 1;
            for (int c = 0; c < NC; c++) begin
                mf[c] = m_flt[c];
                any |= m_flt[c];
                all &= m_dn[c];
                chk("R7 trim", int'(trim[4*c +: 4]), m_trim[c]);
            end
            chk("R4 fault map", int'(fault), int'(mf));
            chk("R5 alarm", int'(alarm), int'(any && !tm));
            chk("R8 cal_done", int'(cal_done), int'(all));
        end
    end

    task automatic wait_win(input int n);
        repeat (n * int'(win_len)) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                model_on = 1;
                // R9 reset state
                chk("R9 alarm", int'(alarm), 0);
                chk("R9 fault", int'(fault), 0);
                chk("R9 done", int'(cal_done), 0);
                for (int c = 0; c < NC; c++) chk("R9 trim", int'(trim[4*c +: 4]), 8);

                half[0] = 4; half[1] = 8; half[2] = 4; half[3] = 4;
                // uncalibrated: counts 8,4,8,8 against target 10 -> all fail
                wait_win(3);
                chk("R4 all channels off target", int'(fault), 15);
                chk("R5 alarm raised", int'(alarm), 1);

                tm = 1'b1;
                @(negedge clk);
                chk("R6 alarm masked in test mode", int'(alarm), 0);
                chk("R6 map kept", int'(fault), 15);
                wait_win(12);
                chk("R8 calibration done", int'(cal_done), 1);
                chk("R7 trim ch0", int'(trim[3:0]), 10);
                chk("R7 trim ch1", int'(trim[7:4]), 14);
                chk("R7 trim ch2", int'(trim[11:8]), 10);
                chk("R7 trim ch3", int'(trim[15:12]), 10);

                tm = 1'b0;
                pulse_clear();
                chk("R5 cleared", int'(fault), 0);
                chk("R8 done dropped", int'(cal_done), 0);
                wait_win(4);
                chk("R4 calibrated pass", int'(fault), 0);
                chk("R2 window restart keeps count stable", int'(alarm), 0);

                // tamper on channel 2
                half[2] = 3;
                wait_win(3);
                chk("R4 tamper ch2", int'(fault), 4);
                chk("R5 alarm on tamper", int'(alarm), 1);
                half[2] = 4;
                wait_win(3);
                chk("R5 sticky after recovery", int'(fault), 4);
                pulse_clear();

                // tolerance band on channel 1 (4 or 5 edges)
                tol = 8'd1;
                half[1] = 7;
                wait_win(4);
                chk("R4 within tolerance", int'(fault), 0);
                tol = 8'd0;
                wait_win(6);
                chk("R4 outside zero tolerance", int'(fault[1]), 1);
                half[1] = 8;
                pulse_clear();

                // saturation: 500 edges per window clamp to 255
                win_len = 16'd1000;
                half[0] = 1;
                target = 8'd255;
                tol = 8'd2;
                wait_win(3);
                chk("R3 saturated count within band", int'(fault[0]), 0);
                chk("R1 slow channel counted as failing", int'(fault[1]), 1);
            end
            begin
                repeat (150000) @(negedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule